// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits on the receive path between an HDLC deframer and the write port of a receive FIFO. It looks at the address field at the start of each frame and decides whether the whole frame is kept or thrown away. A frame that is kept reaches the FIFO side byte for byte, with its start and end markers in place. A frame that is rejected leaves no trace on the output. The only sign of it is a status pulse when the frame ends.

The address field is one or two bytes long. Bit 0 of the first byte is the extension bit: a 1 ends the field after that byte, and a 0 means a second address byte follows. Each address byte has its own comparison pattern and its own enable. The first-byte compare covers either six bits or seven bits, chosen by a mode bit. An all-ones seven-bit pattern is treated as a broadcast address. A global recognition bit turns the whole filter off, and every frame then passes untouched.

The first address byte is held back until the decision can be made. After an accept, the held byte and the rest of the frame are forwarded in order. Software programs the patterns, enables and mode bits through a small write port with registered readback.

Top module: `hdlc_addr_filter`

## Requirements
- R1: After reset, all three configuration registers read 0, out_valid is low and frame_done is low.
- R2: While the recognition bit (register 2, bit 0) is 0, every frame is forwarded unchanged, including a one-byte frame whose extension bit is 0. Each byte appears on the output one cycle after it is taken in, with its sof and eof marks.
- R3: In six-bit mode (register 2, bit 1 = 0), with the first enable set (register 0, bit 7), first-byte bits 7..2 must equal register 0 bits 6..1. First-byte bit 1 is not compared.
- R4: In seven-bit mode (register 2, bit 1 = 1), first-byte bits 7..1 must equal register 0 bits 6..0.
- R5: While the first enable is 0, the first address byte is not compared.
- R6: With the second enable set (register 1, bit 7), second-byte bits 7..1 must equal register 1 bits 6..0. While the second enable is 0, the second byte is not compared.
- R7: With recognition on, a frame that fails the address compare puts no byte on the output.
- R8: A single-byte address whose bits 7..1 are all ones is accepted whenever the first enable is set, whatever the first pattern and the mode.
- R9: In a two-byte address, second-byte bits 7..1 all ones are accepted when the second enable is set, even if the first byte fails its compare. When the second enable is 0, that broadcast value gets no special treatment.
- R10: First-byte bit 0 = 1 marks a one-byte address, and the second byte is then passed as ordinary data. Bit 0 = 0 marks a two-byte address.
- R11: When a two-byte address is accepted, the first byte appears with sof one cycle after the second byte is taken in. The second byte appears in the following cycle. Later bytes keep a one-cycle latency. Input bytes are spaced at least one idle cycle apart.
- R12: With recognition on, a frame whose eof arrives before its address field is complete is discarded.
- R13: frame_done pulses for exactly one cycle, in the cycle after each eof byte is taken in. frame_accept is high in that cycle only if the frame was forwarded.
- R14: Register writes take effect in the next cycle. Readback is registered: cfg_rdata shows the register selected by cfg_raddr one cycle later. The layout is: register 0 = {first enable, first pattern[6:0]}, register 1 = {second enable, second pattern[6:0]}, register 2 = {000000, seven-bit mode, recognition}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration write register select |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_raddr | input | 2 | Configuration read register select |
| cfg_rdata | output | 8 | Registered readback data |
| in_valid | input | 1 | Received byte strobe |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| in_data | input | 8 | Received byte |
| out_valid | output | 1 | FIFO write strobe |
| out_sof | output | 1 | First byte of a forwarded frame |
| out_eof | output | 1 | Last byte of a forwarded frame |
| out_data | output | 8 | Forwarded byte |
| frame_done | output | 1 | One-cycle pulse after each frame end |
| frame_accept | output | 1 | Decision for the frame that just ended |

## Verification
A wrong state-machine state or a corrupted held first byte shows up at the ports within two byte slots. It appears as a missing or extra out_valid, a byte emitted without sof, or a wrong out_data on the first forwarded byte. A wrong accept decision shows on frame_accept one cycle after the eof byte. If bytes leak from a rejected frame, the count of forwarded bytes differs from the expected count before that frame's status pulse. The vectors cover each compare path with patterns that differ from the programmed value only in the bits the mode includes or excludes.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;
  localparam int AF_DW  = 8;          // byte width
  localparam int AF_PW  = AF_DW - 1;  // compared bits (7..1)
  localparam int AF_AW  = 2;          // register select width

  localparam logic [AF_AW-1:0] REG_FIRST  = 2'd0;
  localparam logic [AF_AW-1:0] REG_SECOND = 2'd1;
  localparam logic [AF_AW-1:0] REG_MODE   = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR2,
    ST_PASS,
    ST_DROP
  } af_state_t;

  typedef struct packed {
    logic             en1;
    logic [AF_PW-1:0] pat1;
    logic             en2;
    logic [AF_PW-1:0] pat2;
    logic             wide;
    logic             rec_en;
  } af_cfg_t;
endpackage

// File: rtl/hdlc_af_regs.sv
module hdlc_af_regs
  import hdlc_af_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AF_AW-1:0] wr_addr,
  input  logic [AF_DW-1:0] wr_data,
  input  logic [AF_AW-1:0] rd_addr,
  output logic [AF_DW-1:0] rd_data,
  output af_cfg_t          cfg
);
  localparam int PAD_W = AF_DW - 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        REG_FIRST:  {cfg.en1, cfg.pat1} <= wr_data;
        REG_SECOND: {cfg.en2, cfg.pat2} <= wr_data;
        REG_MODE:   {cfg.wide, cfg.rec_en} <= wr_data[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        REG_FIRST:  rd_data <= {cfg.en1, cfg.pat1};
        REG_SECOND: rd_data <= {cfg.en2, cfg.pat2};
        REG_MODE:   rd_data <= {{PAD_W{1'b0}}, cfg.wide, cfg.rec_en};
        default:    rd_data <= '0;
      endcase
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == REG_FIRST) |=> ({cfg.en1, cfg.pat1} == $past(wr_data))) // R14
    else $error("first register write lost");
endmodule

// File: rtl/hdlc_af_match.sv
module hdlc_af_match
  import hdlc_af_pkg::*;
(
  input  af_cfg_t          cfg,
  input  logic [AF_DW-1:0] byte0,
  input  logic [AF_DW-1:0] byte1,
  output logic             ok_single,
  output logic             ok_double
);
  localparam logic [AF_PW-1:0] ALL_ONES = {AF_PW{1'b1}};

  logic hit1, hit2, bcast1, bcast2, pass1, pass2;

  always_comb begin
    if (cfg.wide)
      hit1 = (byte0[AF_DW-1:1] == cfg.pat1);
    else
      hit1 = (byte0[AF_DW-1:2] == cfg.pat1[AF_PW-1:1]);
    hit2   = (byte1[AF_DW-1:1] == cfg.pat2);
    bcast1 = (byte0[AF_DW-1:1] == ALL_ONES);
    bcast2 = (byte1[AF_DW-1:1] == ALL_ONES);
    pass1  = !cfg.en1 || hit1;
    pass2  = !cfg.en2 || hit2;
    ok_single = pass1 || bcast1;
    ok_double = (cfg.en2 && bcast2) || (pass1 && pass2);
  end
endmodule

// File: rtl/hdlc_af_ctrl.sv
module hdlc_af_ctrl
  import hdlc_af_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rec_en,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [AF_DW-1:0] in_data,
  input  logic             ok_single,
  input  logic             ok_double,
  output logic [AF_DW-1:0] cmp_byte0,
  output logic             out_valid,
  output logic             out_sof,
  output logic             out_eof,
  output logic [AF_DW-1:0] out_data,
  output logic             done,
  output logic             accept
);
  af_state_t        state;
  logic [AF_DW-1:0] held0;
  logic             pend_v, pend_eof;
  logic [AF_DW-1:0] pend_data;
  logic             take_now;

  assign cmp_byte0 = (in_valid && in_sof) ? in_data : held0;
  assign take_now  = !rec_en || (in_data[0] && ok_single);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      held0     <= '0;
      pend_v    <= 1'b0;
      pend_eof  <= 1'b0;
      pend_data <= '0;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_data  <= '0;
      done      <= 1'b0;
      accept    <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      done      <= 1'b0;
      accept    <= 1'b0;
      if (pend_v) begin
        out_valid <= 1'b1;
        out_data  <= pend_data;
        out_eof   <= pend_eof;
        pend_v    <= 1'b0;
      end
      if (in_valid) begin
        if (in_sof) begin
          held0 <= in_data;
          if (in_eof) begin
            done   <= 1'b1;
            accept <= take_now;
            state  <= ST_IDLE;
            if (take_now) begin
              out_valid <= 1'b1;
              out_sof   <= 1'b1;
              out_eof   <= 1'b1;
              out_data  <= in_data;
            end
          end else if (!rec_en || in_data[0]) begin
            if (take_now) begin
              out_valid <= 1'b1;
              out_sof   <= 1'b1;
              out_data  <= in_data;
              state     <= ST_PASS;
            end else begin
              state <= ST_DROP;
            end
          end else begin
            state <= ST_ADDR2;
          end
        end else begin
          case (state)
            ST_ADDR2: begin
              if (ok_double) begin
                out_valid <= 1'b1;
                out_sof   <= 1'b1;
                out_data  <= held0;
                pend_v    <= 1'b1;
                pend_data <= in_data;
                pend_eof  <= in_eof;
              end
              if (in_eof) begin
                done   <= 1'b1;
                accept <= ok_double;
                state  <= ST_IDLE;
              end else begin
                state <= ok_double ? ST_PASS : ST_DROP;
              end
            end
            ST_PASS: begin
              out_valid <= 1'b1;
              out_data  <= in_data;
              out_eof   <= in_eof;
              if (in_eof) begin
                done   <= 1'b1;
                accept <= 1'b1;
                state  <= ST_IDLE;
              end
            end
            ST_DROP: begin
              if (in_eof) begin
                done  <= 1'b1;
                state <= ST_IDLE;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DROP && in_valid && !in_sof) |=> !out_valid) // R7
    else $error("byte leaked from rejected frame");

  AST_DONE_AFTER_EOF: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(in_valid && in_eof)) // R13
    else $error("status pulse without end of frame");

  AST_ACCEPT_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
    accept |-> done) // R13
    else $error("accept outside status pulse");

  AST_HELD_FIRST: assert property (@(posedge clk) disable iff (rst)
    pend_v |-> (out_valid && out_sof)) // R11
    else $error("second address byte queued without first byte");

  AST_PACING: assert property (@(posedge clk) disable iff (rst)
    pend_v |-> !in_valid) // R11
    else $error("input byte collides with queued byte");
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
  import hdlc_af_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [AF_AW-1:0] cfg_addr,
  input  logic [AF_DW-1:0] cfg_wdata,
  input  logic [AF_AW-1:0] cfg_raddr,
  output logic [AF_DW-1:0] cfg_rdata,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [AF_DW-1:0] in_data,
  output logic             out_valid,
  output logic             out_sof,
  output logic             out_eof,
  output logic [AF_DW-1:0] out_data,
  output logic             frame_done,
  output logic             frame_accept
);
  af_cfg_t          cfg;
  logic [AF_DW-1:0] cmp_byte0;
  logic             ok_single, ok_double;

  hdlc_af_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we),
    .wr_addr (cfg_addr),
    .wr_data (cfg_wdata),
    .rd_addr (cfg_raddr),
    .rd_data (cfg_rdata),
    .cfg     (cfg)
  );

  hdlc_af_match u_match (
    .cfg       (cfg),
    .byte0     (cmp_byte0),
    .byte1     (in_data),
    .ok_single (ok_single),
    .ok_double (ok_double)
  );

  hdlc_af_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .rec_en    (cfg.rec_en),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_eof    (in_eof),
    .in_data   (in_data),
    .ok_single (ok_single),
    .ok_double (ok_double),
    .cmp_byte0 (cmp_byte0),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_eof   (out_eof),
    .out_data  (out_data),
    .done      (frame_done),
    .accept    (frame_accept)
  );

  AST_SOF_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid) // R11
    else $error("sof mark without a byte");
endmodule

// File: tb/hdlc_addr_filter_test.sv
module hdlc_addr_filter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [1:0] cfg_raddr = '0;
  logic [7:0] cfg_rdata;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic       out_valid, out_sof, out_eof, frame_done, frame_accept;
  logic [7:0] out_data;

  always #10 clk = ~clk;  // 50 MHz

  hdlc_addr_filter uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
    .out_data(out_data), .frame_done(frame_done), .frame_accept(frame_accept)
  );

  // {first reg, second reg, mode[1:0], byte0, byte1, length, expected accept}
  localparam int NV = 19;
  localparam logic [37:0] VEC [NV] = '{
    {8'h00, 8'h00, 2'b00, 8'h00, 8'h11, 3'd4, 1'b1},  // R2 filter off
    {8'hAA, 8'h00, 2'b01, 8'h55, 8'h00, 3'd3, 1'b1},  // R3 six-bit hit
    {8'hAA, 8'h00, 2'b01, 8'h57, 8'h00, 3'd3, 1'b1},  // R3 bit1 ignored
    {8'hAA, 8'h00, 2'b11, 8'h57, 8'h00, 3'd3, 1'b0},  // R4 bit1 compared
    {8'hAA, 8'h00, 2'b11, 8'h55, 8'h00, 3'd3, 1'b1},  // R4 seven-bit hit
    {8'hAA, 8'h00, 2'b01, 8'h59, 8'h00, 3'd3, 1'b0},  // R7 first byte miss
    {8'h2A, 8'h00, 2'b01, 8'h59, 8'h00, 3'd3, 1'b1},  // R5 first enable off
    {8'hAA, 8'h00, 2'b01, 8'hFF, 8'h00, 3'd3, 1'b1},  // R8 broadcast six
    {8'hAA, 8'hB3, 2'b01, 8'h54, 8'h66, 3'd4, 1'b1},  // R6 two-byte hit
    {8'hAA, 8'hB3, 2'b01, 8'h54, 8'h68, 3'd4, 1'b0},  // R6 second miss
    {8'hAA, 8'hB3, 2'b01, 8'h58, 8'h66, 3'd4, 1'b0},  // R7 first miss, two-byte
    {8'hAA, 8'hB3, 2'b01, 8'h58, 8'hFE, 3'd4, 1'b1},  // R9 broadcast second
    {8'hAA, 8'h33, 2'b01, 8'h58, 8'hFE, 3'd4, 1'b0},  // R9 broadcast, enable off
    {8'hAA, 8'h33, 2'b01, 8'h54, 8'h00, 3'd4, 1'b1},  // R6 second unchecked
    {8'hAA, 8'hB3, 2'b01, 8'h54, 8'h00, 3'd1, 1'b0},  // R12 short frame
    {8'hAA, 8'hB3, 2'b00, 8'h54, 8'h00, 3'd1, 1'b1},  // R2 short, filter off
    {8'hAA, 8'hB3, 2'b01, 8'h55, 8'h00, 3'd3, 1'b1},  // R10 single address
    {8'hAA, 8'hB3, 2'b01, 8'h55, 8'h00, 3'd1, 1'b1},  // R10 one-byte frame
    {8'hAA, 8'h00, 2'b11, 8'hFF, 8'h00, 3'd2, 1'b1}   // R8 broadcast seven
  };
  string vtag [NV];

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [7:0] cap_d   [512];
  logic       cap_sof [512];
  logic       cap_eof [512];
  int cap_n = 0, done_n = 0;
  logic last_acc = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        cap_d[cap_n % 512]   = out_data;
        cap_sof[cap_n % 512] = out_sof;
        cap_eof[cap_n % 512] = out_eof;
        cap_n++;
      end
      if (frame_done) begin
        done_n++;
        last_acc = frame_accept;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [7:0] fbyte(input logic [7:0] b0, input logic [7:0] b1, input int i);
    if (i == 0) return b0;
    if (i == 1) return b1;
    return 8'hC0 + 8'(i);
  endfunction

  task automatic send(input logic [7:0] b0, input logic [7:0] b1, input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == len - 1);
      in_data = fbyte(b0, b1, i);
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    vtag = '{"R2", "R3", "R3", "R4", "R4", "R7", "R5", "R8", "R6", "R6",
             "R7", "R9", "R9", "R6", "R12", "R2", "R10", "R10", "R8"};
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(frame_done == 1'b0, "R1 frame_done after reset", frame_done, 0);
    for (int r = 0; r < 3; r++) begin
      cfg_raddr = 2'(r);
      @(negedge clk);
      chk(cfg_rdata == 8'h00, $sformatf("R1 reg %0d reset value", r), cfg_rdata, 0);
    end

    // R14: write then registered readback
    wr(2'd0, 8'hC5); wr(2'd1, 8'h3C); wr(2'd2, 8'hFF);
    cfg_raddr = 2'd0; @(negedge clk);
    chk(cfg_rdata == 8'hC5, "R14 reg0 readback", cfg_rdata, 8'hC5);
    cfg_raddr = 2'd1; @(negedge clk);
    chk(cfg_rdata == 8'h3C, "R14 reg1 readback", cfg_rdata, 8'h3C);
    cfg_raddr = 2'd2; @(negedge clk);
    chk(cfg_rdata == 8'h03, "R14 reg2 readback", cfg_rdata, 8'h03);

    // vector table
    for (int v = 0; v < NV; v++) begin
      automatic logic [37:0] e = VEC[v];
      automatic int len = int'(e[3:1]);
      automatic bit acc = e[0];
      automatic int base = cap_n;
      automatic int dbase = done_n;
      automatic bit same = 1;
      wr(2'd0, e[37:30]); wr(2'd1, e[29:22]); wr(2'd2, {6'b0, e[21:20]});
      send(e[19:12], e[11:4], len);
      chk(done_n - dbase == 1 && last_acc == acc,
          $sformatf("%s vector %0d status", vtag[v], v), int'(last_acc), int'(acc));
      if (acc) begin
        if (cap_n - base != len) same = 0;
        else
          for (int i = 0; i < len; i++) begin
            if (cap_d[(base + i) % 512] != fbyte(e[19:12], e[11:4], i)) same = 0;
            if (cap_sof[(base + i) % 512] != (i == 0)) same = 0;
            if (cap_eof[(base + i) % 512] != (i == len - 1)) same = 0;
          end
      end else if (cap_n != base) same = 0;
      chk(same, $sformatf("%s vector %0d bytes out", vtag[v], v),
          cap_n - base, acc ? len : 0);
    end

    // R11 and R13: exact cycle of forwarding and of the status pulse
    wr(2'd0, 8'hAA); wr(2'd1, 8'hB3); wr(2'd2, 8'h01);
    @(negedge clk);
    in_valid = 1'b1; in_sof = 1'b1; in_data = 8'h54;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
    chk(out_valid == 1'b0, "R11 first byte held", out_valid, 0);
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'h66;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_sof && out_data == 8'h54, "R11 first byte released",
        out_data, 8'h54);
    @(negedge clk);
    chk(out_valid && !out_sof && out_data == 8'h66, "R11 second byte next cycle",
        out_data, 8'h66);
    in_valid = 1'b1; in_eof = 1'b1; in_data = 8'hC2;
    @(negedge clk);
    in_valid = 1'b0; in_eof = 1'b0;
    chk(out_valid && out_eof && out_data == 8'hC2, "R11 data byte latency",
        out_data, 8'hC2);
    chk(frame_done && frame_accept, "R13 pulse after eof", frame_done, 1);
    @(negedge clk);
    chk(!frame_done && !frame_accept, "R13 pulse one cycle", frame_done, 0);

    // R13 on a rejected frame; R7 nothing forwarded meanwhile
    @(negedge clk);
    in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b1; in_data = 8'h59;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    chk(frame_done && !frame_accept && !out_valid, "R13 reject pulse",
        frame_accept, 0);

    repeat (2) @(negedge clk);
    summary();
  end
endmodule